// File: doc/BRIEF.md
# Configurable SPI Shift Engine

This block is the serial core of an SPI controller in master mode. An upstream agent hands it one parallel word at a time with a start/ready handshake. The engine clocks the word out on MOSI, samples MISO on the opposite edge of each bit, and returns the received word with a one-cycle done strobe. The serial clock comes from an internal half-period counter that the same configuration inputs program.

The configuration inputs set the word length (1 to 16 bits), the bit order, the clock idle level, the clock phase and an internal loopback. They are captured when a word is accepted, so they may be changed freely while a word is in flight. Chip select, FIFOs and register access are handled outside this block.

Top module: `spi_shift_engine`

## Requirements
- R1: Each SCK half-period lasts exactly `cfg_div` clock cycles, and the first SCK edge comes `cfg_div` cycles after the accepting clock edge. A `cfg_div` of 0 means 65536 cycles.
- R2: A `cfg_div` from 1 to 6 is invalid. `cfg_bad` then reads 1 on the cycle after the value is presented, a start is refused (busy stays 0 and no done occurs), and SCK and MOSI do not move. Valid values leave `cfg_bad` at 0.
- R3: `cfg_len` holds the bit count minus one (0 means 1 bit, 15 means 16 bits). Only tx_word bits `cfg_len`..0 are sent. rx_word is right-aligned, and every bit above `cfg_len` is zero.
- R4: When `cfg_msb_first` is 1, bit `cfg_len` goes first and bit 0 goes last. When it is 0, bit 0 goes first. Received bits land at the same positions.
- R5: While no word is in flight, SCK equals `cfg_cpol` (one cycle after it changes). Every word starts and ends at that level.
- R6: With `cfg_cpha` = 0, MOSI is valid before the first SCK edge, MISO is sampled on the first (odd) edge of each bit, and MOSI changes on the second edge. With `cfg_cpha` = 1, MOSI changes on the first edge and MISO is sampled on the second edge.
- R7: With `cfg_loopback` = 1, the received word is built from the engine's own MOSI bits, and the MISO pin has no effect.
- R8: A start is accepted on a rising edge where `start` and `ready` are both 1. busy is then 1 from the next cycle. done is a one-cycle pulse on the cycle busy falls, and rx_word is valid from that cycle. The next word may be accepted on the edge right after done.
- R9: Configuration and tx_word are captured at acceptance. Changes to them while busy do not affect the word in flight.
- R10: While idle, MOSI holds the last value it drove.
- R11: After reset: busy=0, ready=1, done=0, rx_word=0, cfg_bad=0, and SCK=0 with MOSI=0 until the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send tx_word |
| ready | output | 1 | Engine can accept a word |
| tx_word | input | 16 | Word to transmit, right-aligned |
| rx_word | output | 16 | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse when rx_word is updated |
| busy | output | 1 | A word is in flight |
| cfg_div | input | 16 | Half-period length in clocks (0 = 65536) |
| cfg_len | input | 4 | Bits per word minus one |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: on second edge |
| cfg_loopback | input | 1 | Receive from internal MOSI instead of MISO |
| cfg_bad | output | 1 | Presented divider is out of range |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situations to reach are a configuration change in the middle of a word, and a second word accepted on the cycle right after done. Both depend on driving the inputs at an exact moment relative to the engine's own timing. The driver rewrites every configuration input and tx_word one cycle after acceptance. It also issues a same-mode word on the negative edge that carries done. A bench slave model answers on MISO from the observed SCK edges, with its own bit order and phase, so any wrong edge choice shows up as a shifted word. The wrapping divider is exercised with a one-bit word, so that the 65536-cycle half-period stays affordable.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_DIV_W   = 16;
  localparam int unsigned DEF_MIN_DIV = 7;

  // mode bits captured at word acceptance
  typedef struct packed {
    logic msb_first;
    logic cpha;
    logic loopback;
  } spi_mode_t;
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  // a zero divider selects the full counter range
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] cnt;

  assign span = (div == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, div};
  assign tick = run && ({1'b0, cnt} == (span - 1'b1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             tick,
  input  logic             cpha,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic [LEN_W-1:0] bit_idx,
  output logic             sample_en,
  output logic             drive_en,
  output logic [LEN_W-1:0] drive_idx,
  output logic             finish
);
  logic lead;      // next SCK edge is the first edge of the current bit
  logic last_bit;
  logic edge_go;

  assign last_bit  = (bit_idx == len);
  assign edge_go   = busy && tick;
  assign sample_en = edge_go && (lead ^ cpha);
  assign drive_en  = edge_go && ((lead && cpha) || (!lead && !cpha && !last_bit));
  assign drive_idx = lead ? bit_idx : bit_idx + 1'b1;
  assign finish    = edge_go && !lead && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      lead    <= 1'b1;
      bit_idx <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      lead    <= 1'b1;
      bit_idx <= '0;
    end else if (edge_go) begin
      lead <= ~lead;
      if (!lead) begin
        if (last_bit) busy <= 1'b0;
        else          bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_eng_data.sv
module spi_eng_data #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] tx_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              msb_in,
  input  logic              cpha_in,
  input  logic [LEN_W-1:0]  len_q,
  input  logic              msb_q,
  input  logic              loop_q,
  input  logic              drive_en,
  input  logic [LEN_W-1:0]  drive_idx,
  input  logic              sample_en,
  input  logic [LEN_W-1:0]  sample_idx,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              done
);
  // serial step k maps to word bit (len-k) or k depending on order
  function automatic logic [LEN_W-1:0] pos(input logic [LEN_W-1:0] len,
                                           input logic msb,
                                           input logic [LEN_W-1:0] idx);
    return msb ? (len - idx) : idx;
  endfunction

  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_acc;
  logic [DATA_W-1:0] rx_nxt;
  logic              rx_bit;

  assign rx_bit = loop_q ? mosi : miso;

  always_comb begin
    rx_nxt = rx_acc;
    if (sample_en) rx_nxt[pos(len_q, msb_q, sample_idx)] = rx_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '0;
      rx_acc  <= '0;
      rx_word <= '0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (launch) begin
        tx_q   <= tx_in;
        rx_acc <= '0;
        if (!cpha_in) mosi <= tx_in[pos(len_in, msb_in, '0)];
      end else begin
        if (drive_en)  mosi    <= tx_q[pos(len_q, msb_q, drive_idx)];
        if (sample_en) rx_acc  <= rx_nxt;
        if (finish)    rx_word <= rx_nxt;
      end
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int DIV_W   = DEF_DIV_W,
  parameter int MIN_DIV = DEF_MIN_DIV,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              ready,
  input  logic [DATA_W-1:0] tx_word,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              busy,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_msb_first,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_loopback,
  output logic              cfg_bad,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic             div_bad;
  logic             launch;
  logic             tick;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;
  spi_mode_t        mode_q;
  logic [LEN_W-1:0] bit_idx;
  logic [LEN_W-1:0] drive_idx;
  logic             sample_en;
  logic             drive_en;
  logic             finish;

  assign div_bad = (cfg_div != '0) && (cfg_div < DIV_W'(MIN_DIV));
  assign launch  = start && !busy && !div_bad;
  assign ready   = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      len_q   <= '0;
      mode_q  <= '0;
      cfg_bad <= 1'b0;
      sck     <= 1'b0;
    end else begin
      cfg_bad <= div_bad;
      if (launch) begin
        div_q            <= cfg_div;
        len_q            <= cfg_len;
        mode_q.msb_first <= cfg_msb_first;
        mode_q.cpha      <= cfg_cpha;
        mode_q.loopback  <= cfg_loopback;
      end
      if (!busy)     sck <= cfg_cpol;
      else if (tick) sck <= ~sck;
    end
  end

  spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .clear(launch),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  spi_eng_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .tick     (tick),
    .cpha     (mode_q.cpha),
    .len      (len_q),
    .busy     (busy),
    .bit_idx  (bit_idx),
    .sample_en(sample_en),
    .drive_en (drive_en),
    .drive_idx(drive_idx),
    .finish   (finish)
  );

  spi_eng_data #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .tx_in     (tx_word),
    .len_in    (cfg_len),
    .msb_in    (cfg_msb_first),
    .cpha_in   (cfg_cpha),
    .len_q     (len_q),
    .msb_q     (mode_q.msb_first),
    .loop_q    (mode_q.loopback),
    .drive_en  (drive_en),
    .drive_idx (drive_idx),
    .sample_en (sample_en),
    .sample_idx(bit_idx),
    .finish    (finish),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word),
    .done      (done)
  );
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 16,
  parameter int LEN_W   = 4,
  parameter int MIN_DIV = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DIV_W-1:0]  cfg_div,
  input logic              cfg_cpol,
  input logic              sck,
  input logic              mosi,
  input logic [DATA_W-1:0] rx_word,
  input logic [LEN_W-1:0]  len_q
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_ends_word: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r2_bad_div_refused: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg_div != '0 && cfg_div < DIV_W'(MIN_DIV)) |=> !busy);

  a_r5_idle_sck: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> (sck == $past(cfg_cpol)));

  a_r10_idle_mosi: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst)) |-> (mosi == $past(mosi)));

  a_r3_rx_aligned: assert property (@(posedge clk) disable iff (rst)
    done |-> ((rx_word >> ({1'b0, len_q} + 1'b1)) == '0));
endmodule

bind spi_shift_engine spi_shift_engine_chk #(
  .DATA_W (DATA_W),
  .DIV_W  (DIV_W),
  .LEN_W  (LEN_W),
  .MIN_DIV(MIN_DIV)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cfg_div (cfg_div),
  .cfg_cpol(cfg_cpol),
  .sck     (sck),
  .mosi    (mosi),
  .rx_word (rx_word),
  .len_q   (len_q)
);

// File: tb/spi_shift_engine_test.sv
`timescale 1ns/1ps
module spi_shift_engine_test;
  typedef struct {
    logic [15:0] tx;
    logic [15:0] sw;
    int          len;
    bit          msb;
    bit          cpol;
    bit          cpha;
    bit          loopb;
    int          divn;
  } txn_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        start = 0;
  logic        ready;
  logic [15:0] tx_word = '0;
  logic [15:0] rx_word;
  logic        done;
  logic        busy;
  logic [15:0] cfg_div = 16'd7;
  logic [3:0]  cfg_len = 4'd15;
  logic        cfg_msb_first = 1;
  logic        cfg_cpol = 0;
  logic        cfg_cpha = 0;
  logic        cfg_loopback = 0;
  logic        cfg_bad;
  logic        sck;
  logic        mosi;
  logic        miso = 0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_done_cyc = -10;
  int done_cnt = 0;
  txn_t q[$];

  // slave model state
  bit          in_word = 0;
  int          ecnt = 0;
  logic [15:0] cap = '0;
  bit          tim_ok = 1;
  realtime     t_prev = 0;
  bit          prev_done = 0;

  spi_shift_engine uut (
    .clk(clk), .rst(rst), .start(start), .ready(ready), .tx_word(tx_word),
    .rx_word(rx_word), .done(done), .busy(busy), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_msb_first(cfg_msb_first), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_loopback(cfg_loopback), .cfg_bad(cfg_bad),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit bitof(input logic [15:0] w, input int len,
                               input bit msb, input int k);
    return msb ? w[len-k] : w[k];
  endfunction

  function automatic logic [15:0] lowmask(input int len);
    logic [16:0] m;
    m = (17'd1 << (len + 1)) - 17'd1;
    return m[15:0];
  endfunction

  // slave: samples MOSI on the engine's sample edges, drives MISO on the others
  always @(sck) begin
    if (in_word && q.size() > 0) begin
      txn_t cur;
      int   k;
      bit   lead;
      cur = q[0];
      ecnt++;
      if ($realtime - t_prev != cur.divn * 5.0) tim_ok = 0;
      t_prev = $realtime;
      k = (ecnt - 1) / 2;
      lead = ecnt[0];
      if (lead != cur.cpha) cap[cur.msb ? cur.len - k : k] = mosi;
      if (ecnt == 2 * (cur.len + 1)) begin
        in_word = 0;
      end else if (cur.cpha && lead) begin
        #1 miso = bitof(cur.sw, cur.len, cur.msb, k);
      end else if (!cur.cpha && !lead) begin
        #1 miso = bitof(cur.sw, cur.len, cur.msb, k + 1);
      end
    end
  end

  // monitor: pops the expected item on every done pulse
  always @(negedge clk) begin
    if (prev_done) check(!done, "R8", "done wider than one cycle", done, 0);
    prev_done = done;
    if (done) begin
      done_cnt++;
      last_done_cyc = cyc;
      if (q.size() == 0) begin
        check(0, "R8", "done with no word pending", 1, 0);
      end else begin
        txn_t t;
        logic [15:0] exp_rx;
        t = q.pop_front();
        exp_rx = (t.loopb ? t.tx : t.sw) & lowmask(t.len);
        check(rx_word == exp_rx, t.loopb ? "R7" : "R6", "rx_word (R3 R4)",
              rx_word, exp_rx);
        check(cap == (t.tx & lowmask(t.len)), "R4", "serial MOSI word (R3)",
              cap, t.tx & lowmask(t.len));
        check(ecnt == 2 * (t.len + 1), "R5", "SCK edge count",
              ecnt, 2 * (t.len + 1));
        check(tim_ok, "R1", "SCK half-period timing", tim_ok, 1);
        check(sck == t.cpol, "R5", "SCK level at end of word", sck, t.cpol);
      end
    end
  end

  task automatic run_word(input logic [15:0] tx, input logic [15:0] sw,
                          input int len, input bit msb, input bit cpol,
                          input bit cpha, input bit loopb, input int div,
                          input bit scramble, input bit b2b);
    txn_t t;
    bit   cpol_changed;
    realtime t_acc;
    t.tx = tx; t.sw = sw; t.len = len; t.msb = msb; t.cpol = cpol;
    t.cpha = cpha; t.loopb = loopb; t.divn = (div == 0) ? 65536 : div;
    @(negedge clk);
    while (busy) @(negedge clk);
    cpol_changed = (cfg_cpol != cpol);
    cfg_div = div[15:0]; cfg_len = len[3:0]; cfg_msb_first = msb;
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_loopback = loopb; tx_word = tx;
    miso = cpha ? 1'b0 : bitof(sw, len, msb, 0);
    if (cpol_changed) @(negedge clk);
    q.push_back(t);
    start = 1;
    t_acc = $realtime + 2.5;
    @(negedge clk);
    start = 0;
    if (b2b) begin
      check(busy && (cyc == last_done_cyc + 1), "R8",
            "back-to-back accept right after done", cyc - last_done_cyc, 1);
    end
    check(busy, "R8", "busy after accepted start", busy, 1);
    t_prev = t_acc; ecnt = 0; cap = '0; tim_ok = 1; in_word = 1;
    if (scramble) begin
      // R9: disturb every input captured at acceptance
      cfg_len = ~cfg_len; cfg_msb_first = ~msb; cfg_cpha = ~cpha;
      cfg_loopback = ~loopb; cfg_cpol = ~cpol; cfg_div = 16'd13;
      tx_word = ~tx;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(199000 * 5.0);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic m_hold;
    int   dc;
    repeat (4) @(negedge clk);
    // R11: state while held in reset and right after
    check(busy == 0 && done == 0 && ready == 1, "R11", "handshake in reset",
          {busy, done, ready}, 3'b001);
    check(rx_word == 0 && sck == 0 && mosi == 0, "R11", "outputs in reset",
          {rx_word, sck, mosi}, 0);
    rst = 0;
    @(negedge clk);
    check(cfg_bad == 0 && busy == 0, "R11", "after reset", {cfg_bad, busy}, 0);

    // R4/R6 mode variants
    run_word(16'hA5C3, 16'h3C96, 15, 1, 0, 0, 0, 7, 0, 0);
    wait_idle();
    run_word(16'h1E2D, 16'hB00F, 15, 0, 1, 0, 0, 8, 0, 0);
    wait_idle();
    // R3: upper tx bits must not be sent
    run_word(16'hFABC, 16'h5A5A, 11, 1, 0, 1, 0, 9, 0, 0);
    wait_idle();
    run_word(16'h00C6, 16'h0071, 7, 0, 1, 1, 0, 7, 0, 0);
    wait_idle();
    // R7: loopback ignores MISO
    run_word(16'h1234, 16'hFFFF, 15, 1, 0, 0, 1, 7, 0, 0);
    wait_idle();
    run_word(16'h8001, 16'h0000, 15, 0, 1, 1, 1, 7, 0, 0);
    wait_idle();
    // R3: single-bit word
    run_word(16'hFFFE, 16'h0001, 0, 1, 0, 0, 0, 10, 0, 0);
    wait_idle();
    // R9: configuration changed in flight
    run_word(16'h6B3D, 16'hC4E1, 13, 1, 1, 1, 0, 7, 1, 0);
    wait_idle();
    run_word(16'h0F0F, 16'h9119, 9, 0, 0, 0, 0, 11, 1, 0);
    wait_idle();

    // R8: second word on the cycle after done
    run_word(16'hBEEF, 16'h1357, 15, 1, 0, 1, 0, 7, 0, 0);
    run_word(16'hCAFE, 16'h2468, 15, 1, 0, 1, 0, 7, 0, 1);
    wait_idle();

    // R10: MOSI holds while idle; R5: SCK follows polarity while idle
    m_hold = mosi;
    repeat (6) @(negedge clk);
    check(mosi == m_hold, "R10", "idle MOSI hold", mosi, m_hold);
    cfg_cpol = 1;
    repeat (2) @(negedge clk);
    check(sck == 1, "R5", "idle SCK follows polarity 1", sck, 1);
    cfg_cpol = 0;
    repeat (2) @(negedge clk);
    check(sck == 0, "R5", "idle SCK follows polarity 0", sck, 0);

    // R2: out-of-range dividers refused
    for (int d = 3; d <= 6; d += 3) begin
      m_hold = mosi;
      dc = done_cnt;
      cfg_div = d[15:0];
      tx_word = 16'hFFFF;
      cfg_cpha = 0;
      @(negedge clk);
      check(cfg_bad == 1, "R2", "cfg_bad flag", cfg_bad, 1);
      start = 1;
      @(negedge clk);
      start = 0;
      check(busy == 0, "R2", "start refused", busy, 0);
      repeat (20) @(negedge clk);
      check(done_cnt == dc && sck == 0 && mosi == m_hold, "R2",
            "no activity on bad divider", {done_cnt - dc, sck, mosi}, {0, 1'b0, m_hold});
    end
    cfg_div = 16'd7;
    @(negedge clk);
    check(cfg_bad == 0, "R2", "cfg_bad clear on valid divider", cfg_bad, 0);

    // R1: divider 0 means 65536 clocks per half-period
    run_word(16'h0001, 16'h0000, 0, 1, 0, 0, 0, 0, 0, 0);
    wait_idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule